// File: doc/BRIEF.md
# Interrupt Acceptance and Exception Entry Unit

This unit decides whether the processor leaves normal execution on a given clock. It accepts a synchronous exception request carrying a cause code and a 8-bit argument. It also watches four asynchronous interrupt lines: device, timer, inter-processor and machine check. An interrupt line is considered only when the privileged handler mode is off, and only when the 3-bit interrupt priority level (IPL) lets it through.

When something is taken, the unit computes the handler address as the handler base register plus a fixed offset. It records the interrupted PC together with the previous mode in bit 0, and it switches to privileged handler mode. All of this happens on one clock edge, and the edge is marked by a single-cycle strobe. The exception argument is the call-gate number for call-gate entries and is stored as the error code; an interrupt stores zero. A cause code outside the defined set raises an error strobe instead of redirecting.

Top module: `exc_vector_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, every output reads zero: `new_pc_o`, `exc_addr_o`, `pal_mode_o`, `err_code_o`, `taken_o` and `bad_cause_o`.
- R2: No interrupt is taken while `pal_mode_i` is 1. A synchronous exception is still taken in that case.
- R3: The IPL thresholds are as follows. Device is eligible at IPL 0 to 3. Timer is eligible at IPL 4 or below. Inter-processor is eligible at IPL 5 or below. Machine check is eligible at IPL 6 or below. At IPL 7 no interrupt is eligible.
- R4: Among eligible interrupts, machine check beats inter-processor, which beats timer, which beats device.
- R5: The cause encoding on `exc_cause_i` is 0 reset, 1 machine check, 2 inter-processor, 3 timer, 4 device, 5 memory fault, 6 unaligned, 7 illegal opcode, 8 arithmetic and 9 FP disabled. The offset for cause c in 0..9 is c×0x80. Interrupts use the offsets of causes 4, 3, 2 and 1.
- R6: Cause 10 is a call gate with number n = `exc_code_i[7:0]`. If n[7] is 1, the offset is 0x2000 + (n−0x80)×64. If n[7] is 0, the offset is 0x1000 + n×64.
- R7: On a take, `exc_addr_o` equals `cur_pc_i` with bit 0 replaced by the OR of `cur_pc_i[0]` and `pal_mode_i`, both sampled at that edge.
- R8: On a take, `new_pc_o` equals `pal_base_i` + offset, `pal_mode_o` becomes 1, and `taken_o` is high for exactly that cycle.
- R9: When `exc_req_i` is high, the exception is handled and any pending interrupt is ignored for that edge.
- R10: A cause code of 11 to 15 with `exc_req_i` high pulses `bad_cause_o` for one cycle. In that case `taken_o` stays low and the PC, address, code and mode outputs behave as in a cycle with nothing taken.
- R11: On an interrupt take, `err_code_o` becomes 0. On an exception take, it captures `exc_code_i`.
- R12: In a cycle with nothing taken, `new_pc_o`, `exc_addr_o` and `err_code_o` hold their values, and `pal_mode_o` follows `pal_mode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_dev_i | input | 1 | Device interrupt pending |
| irq_timer_i | input | 1 | Timer interrupt pending |
| irq_ipi_i | input | 1 | Inter-processor interrupt pending |
| irq_mchk_i | input | 1 | Machine-check interrupt pending |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | 4 | Exception cause code |
| exc_code_i | input | CODE_W | Error code; low 8 bits are the call-gate number |
| cur_pc_i | input | AW | PC of the current instruction |
| pal_base_i | input | AW | Handler base register |
| ipl_i | input | 3 | Current interrupt priority level |
| pal_mode_i | input | 1 | Privileged handler mode is active |
| new_pc_o | output | AW | Handler entry address |
| exc_addr_o | output | AW | Saved return address with mode in bit 0 |
| pal_mode_o | output | 1 | Updated privileged mode flag |
| err_code_o | output | CODE_W | Stored error code |
| taken_o | output | 1 | One-cycle strobe on entry |
| bad_cause_o | output | 1 | One-cycle strobe on undefined cause |

## Verification
Some rules can be checked on every cycle, and the assertions cover them. An interrupt is never taken in privileged mode or at IPL 7. A take always sets the mode and saves the old mode in bit 0. A take and an error never occur together. The outputs hold when nothing is taken, and an interrupt take clears the code.

Other behaviour can only be shown by the bench's scenarios. This covers the exact offset values for every cause and call-gate number, the threshold at each IPL and the priority order among lines. It also covers exceptions overriding interrupts and undefined causes leaving state untouched. For these the bench compares against its reference model.

// File: rtl/exv_pkg.sv
package exv_pkg;

  localparam int CAUSE_W = 4;
  localparam int OFF_W   = 16;

  typedef enum logic [CAUSE_W-1:0] {
    CS_RESET   = 4'd0,
    CS_MCHK    = 4'd1,
    CS_IPI     = 4'd2,
    CS_TIMER   = 4'd3,
    CS_DEVICE  = 4'd4,
    CS_MEMFLT  = 4'd5,
    CS_UNALIGN = 4'd6,
    CS_ILLOP   = 4'd7,
    CS_ARITH   = 4'd8,
    CS_FPOFF   = 4'd9,
    CS_GATE    = 4'd10
  } cause_e;

  localparam logic [OFF_W-1:0] GATE_PRIV_BASE = 16'h1000;
  localparam logic [OFF_W-1:0] GATE_USER_BASE = 16'h2000;

  // Fixed causes are spaced 128 bytes apart.
  function automatic logic [OFF_W-1:0] fixed_offset(input logic [CAUSE_W-1:0] c);
    return {5'd0, c, 7'd0};
  endfunction

  // Call gates: two regions of 64-byte slots, chosen by bit 7.
  function automatic logic [OFF_W-1:0] gate_offset(input logic [7:0] n);
    logic [OFF_W-1:0] base;
    base = n[7] ? GATE_USER_BASE : GATE_PRIV_BASE;
    return base + {3'd0, n[6:0], 6'd0};
  endfunction

  function automatic logic cause_known(input logic [CAUSE_W-1:0] c);
    return c <= CS_GATE;
  endfunction

endpackage

// File: rtl/exv_irq_pick.sv
module exv_irq_pick #(
  parameter int IPL_W    = 3,
  parameter int DEV_MAX  = 3,
  parameter int TMR_MAX  = 4,
  parameter int IPI_MAX  = 5,
  parameter int MCHK_MAX = 6
) (
  input  logic [3:0]       req,      // [0] dev, [1] timer, [2] ipi, [3] mchk
  input  logic [IPL_W-1:0] ipl,
  input  logic             blocked,
  output logic             hit,
  output logic [exv_pkg::CAUSE_W-1:0] cause
);
  import exv_pkg::*;

  localparam int NSRC = 4;
  localparam int LIM [NSRC] = '{DEV_MAX, TMR_MAX, IPI_MAX, MCHK_MAX};
  localparam logic [CAUSE_W-1:0] SRC_CAUSE [NSRC] = '{CS_DEVICE, CS_TIMER, CS_IPI, CS_MCHK};

  logic [NSRC-1:0] elig;

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig[g] = req[g] && !blocked && (int'(ipl) <= LIM[g]);
  end

  // Ascending scan: later (higher-priority) sources override.
  always_comb begin
    hit   = 1'b0;
    cause = CS_RESET;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i]) begin
        hit   = 1'b1;
        cause = SRC_CAUSE[i];
      end
    end
  end

endmodule

// File: rtl/exv_vec_gen.sv
module exv_vec_gen (
  input  logic [exv_pkg::CAUSE_W-1:0] cause,
  input  logic [7:0]                  gate_num,
  output logic [exv_pkg::OFF_W-1:0]   offset,
  output logic                        known
);
  import exv_pkg::*;

  always_comb begin
    known  = cause_known(cause);
    offset = (cause == CS_GATE) ? gate_offset(gate_num) : fixed_offset(cause);
  end

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter int AW     = 64,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_dev_i,
  input  logic              irq_timer_i,
  input  logic              irq_ipi_i,
  input  logic              irq_mchk_i,
  input  logic              exc_req_i,
  input  logic [3:0]        exc_cause_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [AW-1:0]     cur_pc_i,
  input  logic [AW-1:0]     pal_base_i,
  input  logic [2:0]        ipl_i,
  input  logic              pal_mode_i,
  output logic [AW-1:0]     new_pc_o,
  output logic [AW-1:0]     exc_addr_o,
  output logic              pal_mode_o,
  output logic [CODE_W-1:0] err_code_o,
  output logic              taken_o,
  output logic              bad_cause_o
);
  import exv_pkg::*;

  logic                 irq_hit;
  logic [CAUSE_W-1:0]   irq_cause;
  logic [CAUSE_W-1:0]   sel_cause;
  logic [OFF_W-1:0]     sel_offset;
  logic                 sel_known;
  logic                 take_now;
  logic                 bad_now;
  logic [AW-1:0]        target_pc;
  logic [AW-1:0]        save_addr;

  exv_irq_pick #(.IPL_W(3)) pick_i (
    .req     ({irq_mchk_i, irq_ipi_i, irq_timer_i, irq_dev_i}),
    .ipl     (ipl_i),
    .blocked (pal_mode_i),
    .hit     (irq_hit),
    .cause   (irq_cause)
  );

  assign sel_cause = exc_req_i ? exc_cause_i : irq_cause;

  exv_vec_gen vec_i (
    .cause    (sel_cause),
    .gate_num (exc_code_i[7:0]),
    .offset   (sel_offset),
    .known    (sel_known)
  );

  assign take_now  = exc_req_i ? sel_known : irq_hit;
  assign bad_now   = exc_req_i && !sel_known;
  assign target_pc = pal_base_i + AW'(sel_offset);
  assign save_addr = {cur_pc_i[AW-1:1], cur_pc_i[0] | pal_mode_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_pc_o    <= '0;
      exc_addr_o  <= '0;
      pal_mode_o  <= 1'b0;
      err_code_o  <= '0;
      taken_o     <= 1'b0;
      bad_cause_o <= 1'b0;
    end else begin
      taken_o     <= take_now;
      bad_cause_o <= bad_now;
      if (take_now) begin
        new_pc_o   <= target_pc;
        exc_addr_o <= save_addr;
        pal_mode_o <= 1'b1;
        err_code_o <= exc_req_i ? exc_code_i : '0;
      end else begin
        pal_mode_o <= pal_mode_i;
      end
    end
  end

endmodule

// File: rtl/exv_vector_chk.sv
module exv_vector_chk #(
  parameter int AW     = 64,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc_req_i,
  input logic [2:0]        ipl_i,
  input logic              pal_mode_i,
  input logic              irq_hit,
  input logic [AW-1:0]     new_pc_o,
  input logic [AW-1:0]     exc_addr_o,
  input logic              pal_mode_o,
  input logic [CODE_W-1:0] err_code_o,
  input logic              taken_o,
  input logic              bad_cause_o
);

  // R2
  pal_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_mode_i && !exc_req_i) |=> !taken_o);

  // R3
  ipl7_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl_i == 3'd7 && !exc_req_i) |=> !taken_o);

  // R8
  take_sets_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> pal_mode_o);

  // R7
  saved_mode_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && pal_mode_i) |=> (!taken_o || exc_addr_o[0]));

  // R10
  take_xor_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(taken_o && bad_cause_o));

  // R12
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> ($stable(new_pc_o) && $stable(exc_addr_o) && $stable(err_code_o)));

  // R11
  irq_clears_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hit && !exc_req_i) |=> (taken_o && err_code_o == '0));

endmodule

bind exc_vector_unit exv_vector_chk #(.AW(AW), .CODE_W(CODE_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .exc_req_i   (exc_req_i),
  .ipl_i       (ipl_i),
  .pal_mode_i  (pal_mode_i),
  .irq_hit     (irq_hit),
  .new_pc_o    (new_pc_o),
  .exc_addr_o  (exc_addr_o),
  .pal_mode_o  (pal_mode_o),
  .err_code_o  (err_code_o),
  .taken_o     (taken_o),
  .bad_cause_o (bad_cause_o)
);

// File: tb/exc_vector_unit_tb_top.sv
module exc_vector_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev = 0, tmr = 0, ipi = 0, mchk = 0, req = 0, mode = 0;
  logic [3:0] cause = 0;
  logic [CW-1:0] code = 0;
  logic [AW-1:0] pc = 0, base = 0;
  logic [2:0] ipl = 0;
  logic [AW-1:0] new_pc, exc_addr;
  logic pal_o, taken, bad;
  logic [CW-1:0] ecode;

  // reference state
  logic [AW-1:0] m_pc = 0, m_addr = 0;
  logic m_mode = 0, m_taken = 0, m_bad = 0;
  logic [CW-1:0] m_code = 0;

  int checks = 0, fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_vector_unit #(.AW(AW), .CODE_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_dev_i(dev), .irq_timer_i(tmr), .irq_ipi_i(ipi),
    .irq_mchk_i(mchk), .exc_req_i(req), .exc_cause_i(cause), .exc_code_i(code),
    .cur_pc_i(pc), .pal_base_i(base), .ipl_i(ipl), .pal_mode_i(mode),
    .new_pc_o(new_pc), .exc_addr_o(exc_addr), .pal_mode_o(pal_o),
    .err_code_o(ecode), .taken_o(taken), .bad_cause_o(bad));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d expected<20000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int model_offset(input int c, input int n);
    case (c)
      0: return 'h000;  1: return 'h080;  2: return 'h100;  3: return 'h180;
      4: return 'h200;  5: return 'h280;  6: return 'h300;  7: return 'h380;
      8: return 'h400;  9: return 'h480;
      default: return (n >= 128) ? 'h2000 + (n - 128) * 64 : 'h1000 + n * 64;
    endcase
  endfunction

  // Advance the reference by one edge using the current inputs.
  task automatic model_step();
    int off = -1;
    logic tk = 0;
    logic bd = 0;
    if (req) begin
      if (int'(cause) > 10) bd = 1;
      else begin tk = 1; off = model_offset(int'(cause), int'(code)); end
    end else if (!mode) begin
      int l = int'(ipl);
      if (mchk && l <= 6)     begin tk = 1; off = 'h080; end
      else if (ipi && l <= 5) begin tk = 1; off = 'h100; end
      else if (tmr && l <= 4) begin tk = 1; off = 'h180; end
      else if (dev && l <= 3) begin tk = 1; off = 'h200; end
    end
    m_taken = tk;
    m_bad = bd;
    if (tk) begin
      m_pc = base + AW'(off);
      m_addr = pc | AW'(mode);
      m_code = req ? code : '0;
      m_mode = 1;
    end else m_mode = mode;
  endtask

  task automatic step(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "new_pc", new_pc, m_pc);
    chk(tag, "exc_addr", exc_addr, m_addr);
    chk(tag, "pal_mode", AW'(pal_o), AW'(m_mode));
    chk(tag, "err_code", AW'(ecode), AW'(m_code));
    chk(tag, "taken", AW'(taken), AW'(m_taken));
    chk(tag, "bad_cause", AW'(bad), AW'(m_bad));
  endtask

  task automatic irqs(input logic [3:0] v);
    {mchk, ipi, tmr, dev} = v;
  endtask

  initial begin
    base = 64'hFFFF_0000_0010_0000;
    pc   = 64'h0000_0000_0040_1230;
    repeat (3) @(negedge clk);
    // R1: during reset and first edge
    chk("R1", "new_pc", new_pc, 0);
    chk("R1", "taken", AW'(taken), 0);
    chk("R1", "pal_mode", AW'(pal_o), 0);
    chk("R1", "exc_addr", exc_addr, 0);
    rst_n = 1;
    step("R1");

    // R5: each fixed cause
    req = 1;
    for (int c = 0; c < 10; c++) begin
      cause = 4'(c); code = 8'(c * 3 + 1); pc = pc + 4;
      step("R5");
    end
    // R6: call gates both regions and boundaries
    cause = 4'd10;
    foreach (code[i]) ; // no-op
    for (int k = 0; k < 6; k++) begin
      int ns [6] = '{0, 1, 63, 127, 128, 255};
      code = 8'(ns[k]);
      step("R6");
    end
    // R10: undefined causes leave state alone
    for (int c = 11; c < 16; c++) begin cause = 4'(c); pc = pc + 8; step("R10"); end
    req = 0;
    // R12: idle, mode follows input
    mode = 1; step("R12");
    mode = 0; step("R12");

    // R3: each single line across all IPL values
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 8; l++) begin
        irqs(4'(1 << s)); ipl = 3'(l); pc = pc + 4;
        step("R3");
      end
    end
    // R4: combinations of lines across IPL
    for (int v = 1; v < 16; v++) begin
      for (int l = 0; l < 8; l++) begin
        irqs(4'(v)); ipl = 3'(l);
        step("R4");
      end
    end
    // R2: privileged mode blocks every line at every IPL
    mode = 1;
    for (int l = 0; l < 8; l++) begin irqs(4'hF); ipl = 3'(l); step("R2"); end
    // R2 / R7: exception still taken in privileged mode, mode saved in bit 0
    req = 1; cause = 4'd6; code = 8'h5A; pc = 64'h0000_0000_0000_2220; step("R7");
    pc = 64'h0000_0000_0000_3331; step("R7");
    mode = 0; pc = 64'h0000_0000_0000_4441; step("R7");
    // R9: exception beats pending interrupt
    irqs(4'hF); ipl = 0; cause = 4'd8; code = 8'h77; step("R9");
    cause = 4'd10; code = 8'h85; step("R9");
    // R11: interrupt after exception clears the code
    req = 0; irqs(4'b0001); ipl = 0; step("R11");
    // R8: strobe lasts one cycle; idle afterwards
    irqs(4'h0); step("R8");
    base = 64'h0000_0000_00FF_F000; req = 1; cause = 4'd5; step("R8");
    req = 0; step("R8");
    // R10 with interrupt pending: error, no redirect
    req = 1; cause = 4'd13; irqs(4'hF); step("R10");
    req = 0; irqs(4'h0); step("R12");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule